// File: doc/BRIEF.md
# Quadrature Mouse Interrupt Interface

This block takes the two quadrature pairs of a mouse (horizontal phases A and B, vertical phases A and B) and its two buttons. It resynchronises them to the system clock and then works in one of two ways. The choice comes from an enable bit in a control byte. With interrupts enabled, it produces single-cycle request pulses for left, right, up and down motion. With interrupts disabled, it places the raw phase levels in a status byte so that software can poll them.

For each axis, an interrupt state is formed as phase A XOR phase B XOR a software polarity bit. A request fires only when this state goes from 0 to 1. The direction is read from one phase level at that moment: phase A for the horizontal axis and phase B for the vertical axis. No position counter is kept. A write strobe clears the latched status byte. The status is then refreshed from the inputs on the next clock.

Top module: `qmi_mouse_irq`

## Requirements
- R1: While reset is asserted and at the first sample after it, all four request outputs are low and `rdata_o` reads 0xC0.
- R2: Each mouse input passes through a two-flop synchroniser. A level applied before a rising edge appears in `rdata_o` after the third rising edge and can cause a request pulse no earlier than that edge.
- R3: The horizontal interrupt state is XA^XB^`pol_i[6]` and the vertical interrupt state is YA^YB^`pol_i[7]`, both taken from synchronised phases. A request fires only on a 0-to-1 change of that state between consecutive clocks.
- R4: When a horizontal request fires, `irq_left_o` pulses if the synchronised XA is 1 and `irq_right_o` pulses if it is 0.
- R5: When a vertical request fires, `irq_down_o` pulses if the synchronised YB is 1 and `irq_up_o` pulses if it is 0.
- R6: Each request is a one-clock pulse, and the two outputs of one axis never pulse together. No request is raised in a cycle sampled with `ctrl_i[3]` = 0.
- R7: When `ctrl_i[3]` = 0, status bits 3..0 hold XA, XB, YA and YB, with YB in bit 0. When `ctrl_i[3]` = 1, those bits read 0.
- R8: `rdata_o` bits 7 and 6 always read 1. Bit 4 is the synchronised left button and bit 5 is the synchronised right button.
- R9: A clock edge sampled with `wr_i` = 1 loads zero into the status byte, so `rdata_o` reads 0xC0 until the next edge reloads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xa_i | input | 1 | Horizontal phase A, asynchronous |
| xb_i | input | 1 | Horizontal phase B, asynchronous |
| ya_i | input | 1 | Vertical phase A, asynchronous |
| yb_i | input | 1 | Vertical phase B, asynchronous |
| btn_l_i | input | 1 | Left button, asynchronous |
| btn_r_i | input | 1 | Right button, asynchronous |
| ctrl_i | input | 8 | Control byte; bit 3 enables interrupts |
| pol_i | input | 8 | Polarity byte; bit 6 horizontal, bit 7 vertical |
| wr_i | input | 1 | Status write strobe (clears) |
| rdata_o | output | 8 | Status read data |
| irq_left_o | output | 1 | Left motion request pulse |
| irq_right_o | output | 1 | Right motion request pulse |
| irq_up_o | output | 1 | Up motion request pulse |
| irq_down_o | output | 1 | Down motion request pulse |

## Verification
Two things can land on the same edge. The clear from a status write can arrive on the edge that would load new phase or button levels. Separately, both axes can produce a request on the same clock. The bench places write strobes on the very cycles when freshly synchronised phases reach the status byte. It also moves both axes in one step and flips the polarity bits while a phase pair is still. On every clock, a behavioural model decides which event wins: the cleared byte for one cycle followed by the reload, and two independent pulses on separate outputs.

// File: rtl/qmi_pkg.sv
package qmi_pkg;
  localparam int IN_W      = 6;
  localparam int ST_W      = 6;
  localparam int EN_BIT    = 3;
  localparam int POLX_BIT  = 6;
  localparam int POLY_BIT  = 7;
  localparam int CTRL_W    = 8;
  localparam int RD_W      = 8;
  localparam logic [RD_W-ST_W-1:0] RD_TOP = '1;

  typedef struct packed {
    logic xa;
    logic xb;
    logic ya;
    logic yb;
    logic bl;
    logic br;
  } qmi_in_t;
endpackage

// File: rtl/qmi_sync.sv
module qmi_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/qmi_axis.sv
module qmi_axis #(
  parameter bit DIR_FROM_B = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_i,
  input  logic b_i,
  input  logic pol_i,
  input  logic en_i,
  output logic irq_hi_o,
  output logic irq_lo_o
);
  logic st, sel, fire;
  logic prev_q, hi_q, lo_q;
  logic prev_d, hi_d, lo_d;

  generate
    if (DIR_FROM_B) begin : g_sel_b
      assign sel = b_i;
    end else begin : g_sel_a
      assign sel = a_i;
    end
  endgenerate

  always_comb begin
    st     = a_i ^ b_i ^ pol_i;
    fire   = en_i & st & ~prev_q;
    prev_d = st;
    hi_d   = fire & sel;
    lo_d   = fire & ~sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      prev_q <= prev_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign irq_hi_o = hi_q;
  assign irq_lo_o = lo_q;

  // R6: one-clock pulse, never both outputs at once
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi_o || irq_lo_o) |=> !(irq_hi_o || irq_lo_o));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_hi_o && irq_lo_o));
  // R6: disabled sample raises nothing
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !(irq_hi_o || irq_lo_o));
endmodule

// File: rtl/qmi_mouse_irq.sv
module qmi_mouse_irq
  import qmi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xa_i,
  input  logic              xb_i,
  input  logic              ya_i,
  input  logic              yb_i,
  input  logic              btn_l_i,
  input  logic              btn_r_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [CTRL_W-1:0] pol_i,
  input  logic              wr_i,
  output logic [RD_W-1:0]   rdata_o,
  output logic              irq_left_o,
  output logic              irq_right_o,
  output logic              irq_up_o,
  output logic              irq_down_o
);
  qmi_in_t raw, syn;
  logic [IN_W-1:0] syn_bits;
  logic [ST_W-1:0] status_q, status_d;
  logic en;

  assign raw = '{xa: xa_i, xb: xb_i, ya: ya_i, yb: yb_i, bl: btn_l_i, br: btn_r_i};
  assign en  = ctrl_i[EN_BIT];

  qmi_sync #(.W(IN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw),
    .q_o   (syn_bits)
  );
  assign syn = qmi_in_t'(syn_bits);

  qmi_axis #(.DIR_FROM_B(1'b0)) u_axis_x (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_i      (syn.xa),
    .b_i      (syn.xb),
    .pol_i    (pol_i[POLX_BIT]),
    .en_i     (en),
    .irq_hi_o (irq_left_o),
    .irq_lo_o (irq_right_o)
  );

  qmi_axis #(.DIR_FROM_B(1'b1)) u_axis_y (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_i      (syn.ya),
    .b_i      (syn.yb),
    .pol_i    (pol_i[POLY_BIT]),
    .en_i     (en),
    .irq_hi_o (irq_down_o),
    .irq_lo_o (irq_up_o)
  );

  always_comb begin
    if (wr_i) begin
      status_d = '0;
    end else begin
      status_d = {syn.br, syn.bl,
                  en ? 4'b0000 : {syn.xa, syn.xb, syn.ya, syn.yb}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign rdata_o = {RD_TOP, status_q};

  // R9: a write leaves the cleared byte visible for one cycle
  a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (rdata_o == 8'hC0));
  // R7: enabled mode hides the phase bits
  a_r7_enabled_hides: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (rdata_o[3:0] == 4'b0000));
  // R8: upper bits always set
  a_r8_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[7:6] == 2'b11);
  // R6: the axes' pulses each last one clock
  a_r6_left_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_left_o |=> !irq_left_o);
endmodule

// File: tb/qmi_mouse_irq_tb.sv
module qmi_mouse_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic xa, xb, ya, yb, bl, br, wr;
  logic [7:0] ctrl, pol;
  logic [7:0] rdata;
  logic il, ir, iu, idn;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  qmi_mouse_irq u_dut (
    .clk(clk), .rst_n(rst_n), .xa_i(xa), .xb_i(xb), .ya_i(ya), .yb_i(yb),
    .btn_l_i(bl), .btn_r_i(br), .ctrl_i(ctrl), .pol_i(pol), .wr_i(wr),
    .rdata_o(rdata), .irq_left_o(il), .irq_right_o(ir),
    .irq_up_o(iu), .irq_down_o(idn)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // behavioural reference: input history in a queue, integers for state
  int hist[$];
  int m_prevx, m_prevy;
  int e_l, e_r, e_u, e_d, e_stat;

  function automatic int pack_in();
    return (xa << 5) | (xb << 4) | (ya << 3) | (yb << 2) | (bl << 1) | br;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {0, 0};
      m_prevx = 0; m_prevy = 0;
      e_l = 0; e_r = 0; e_u = 0; e_d = 0; e_stat = 0;
    end else begin
      int s, sxa, sxb, sya, syb, sbl, sbr, stx, sty, en;
      s = hist[0];
      sxa = (s >> 5) & 1; sxb = (s >> 4) & 1; sya = (s >> 3) & 1;
      syb = (s >> 2) & 1; sbl = (s >> 1) & 1; sbr = s & 1;
      en = ctrl[3];
      stx = sxa ^ sxb ^ pol[6];
      sty = sya ^ syb ^ pol[7];
      e_l = (en && stx && !m_prevx && sxa) ? 1 : 0;
      e_r = (en && stx && !m_prevx && !sxa) ? 1 : 0;
      e_d = (en && sty && !m_prevy && syb) ? 1 : 0;
      e_u = (en && sty && !m_prevy && !syb) ? 1 : 0;
      m_prevx = stx; m_prevy = sty;
      if (wr) e_stat = 0;
      else e_stat = (sbr << 5) | (sbl << 4) |
                    (en ? 0 : ((sxa << 3) | (sxb << 2) | (sya << 1) | syb));
      void'(hist.pop_front());
      hist.push_back(pack_in());
    end
  end

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      chk("R8 rdata (R7 R9 R2)", rdata, 8'hC0 | e_stat);
      chk("R4 left", il, e_l);
      chk("R4 right", ir, e_r);
      chk("R5 up", iu, e_u);
      chk("R5 down", idn, e_d);
    end
    if (cycles > 20000 && !done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  int px = 0, py = 0;

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic set_x(int p);
    px = p & 3;
    xa = (px < 2); xb = (px == 1 || px == 2);
  endtask

  task automatic set_y(int p);
    py = p & 3;
    ya = (py < 2); yb = (py == 1 || py == 2);
  endtask

  initial begin
    rst_n = 0; xa = 0; xb = 0; ya = 0; yb = 0; bl = 0; br = 0;
    wr = 0; ctrl = 8'h00; pol = 8'h00;
    // R1: reset state compared while reset holds
    idle(3);
    rst_n = 1;
    idle(2);
    // R7: disabled mode, phases visible; R2 latency checked each clock
    for (int k = 0; k < 8; k++) begin
      set_x(px + 1); idle(1); set_y(py - 1); idle(4);
    end
    // R8: buttons
    bl = 1; idle(5); br = 1; idle(5); bl = 0; idle(5);
    // R9: writes, including on the cycle new levels land
    wr = 1; idle(1); wr = 0; idle(3);
    set_x(px + 1); idle(2); wr = 1; idle(1); wr = 0; idle(4);
    br = 0; idle(1); wr = 1; idle(2); wr = 0; idle(4);
    // R3 R4 R5: enabled, forward and backward in both axes
    ctrl = 8'h08; idle(4);
    for (int k = 0; k < 8; k++) begin set_x(px + 1); idle(4); end
    for (int k = 0; k < 8; k++) begin set_x(px - 1); idle(4); end
    for (int k = 0; k < 8; k++) begin set_y(py + 1); idle(4); end
    for (int k = 0; k < 8; k++) begin set_y(py - 1); idle(4); end
    // both axes at once
    for (int k = 0; k < 8; k++) begin set_x(px + 1); set_y(py + 1); idle(4); end
    // R3: polarity flips with still phases
    pol = 8'h40; idle(4); pol = 8'hC0; idle(4); pol = 8'h00; idle(4);
    pol = 8'hC0;
    for (int k = 0; k < 8; k++) begin set_x(px - 1); set_y(py + 1); idle(3); end
    // R6: fast stepping, then disable while moving
    for (int k = 0; k < 12; k++) begin set_x(px + 1); set_y(py - 1); idle(1); end
    ctrl = 8'hF7;
    for (int k = 0; k < 8; k++) begin set_x(px + 1); set_y(py + 1); idle(3); end
    ctrl = 8'h08; wr = 1; idle(1); wr = 0;
    for (int k = 0; k < 6; k++) begin set_x(px + 1); idle(3); end
    // R1: reset again mid-run
    rst_n = 0; idle(2); rst_n = 1; idle(6);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule